// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Command Decoder

This block sits behind a serial front end of a two-channel current-output converter. Each time the front end delivers a strobe with a 6-bit operation code and an 8-bit value, the block decodes the operation and updates its control state on the next clock edge. That state is a staging (input) register and an active register for each channel, a shutdown flag for each channel, a 3-bit full-scale range index for each channel, and one bit that picks the internal or external reference.

A value can go straight to the active register, or it can be staged in the input register and moved across later. Both channels can then change at once. Shutdown only gates the code seen by the analog array: the registers can still be written while a channel is off. Codes outside the defined set do nothing. The value field matters only for load operations.

Top module: `twin_dac_cmdproc`

## Requirements
- R1: While reset is held and after its release, before any command: all staging and active registers read 0, `ref_int` is 0 (external reference), both range indices are 0, and neither channel is shut down.
- R2: Code 6'b000001 writes `cmd_data` into both staging and both active registers. 6'b000010 does this for channel A only, and 6'b000011 for channel B only.
- R3: Codes 6'b000100 (both), 6'b000101 (A) and 6'b000110 (B) write `cmd_data` into staging registers only, and the active registers keep their values.
- R4: Codes 6'b000111 (both), 6'b001001 (A) and 6'b001010 (B) copy the staging register into the active register of the named channels, and `cmd_data` is ignored.
- R5: Code 6'b001011 sets `ref_int` to 1 (internal reference), and 6'b001100 clears it to 0 (external reference).
- R6: Codes 6'b001101, 6'b001110 and 6'b001111 set the shutdown flag of both channels, channel A and channel B respectively. Codes 6'b101101, 6'b101110 and 6'b101111 clear them in the same order.
- R7: Codes 6'b010000 plus k, for k from 0 to 5, set the channel A range index to k. Codes 6'b110000 plus k do the same for channel B. Codes whose low three bits are 6 or 7 leave the range unchanged.
- R8: While a channel is shut down, its `drive_*` output is 0 and its active register keeps its value. When the channel powers up, `drive_*` again equals the active register.
- R9: Load and transfer operations take effect on a channel that is shut down.
- R10: An undefined code (for example 6'b001000, 6'b010110, 6'b111111), the no-op 6'b000000, or a cycle with `cmd_valid` low changes no output.
- R11: A command sampled at a rising clock edge is visible on the outputs right after that edge, and the outputs do not change at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 6 | Operation code |
| cmd_data | input | DATA_W | Value for load operations |
| hold_a | output | DATA_W | Channel A staging register |
| hold_b | output | DATA_W | Channel B staging register |
| act_a | output | DATA_W | Channel A active register |
| act_b | output | DATA_W | Channel B active register |
| drive_a | output | DATA_W | Channel A code to the array, 0 while shut down |
| drive_b | output | DATA_W | Channel B code to the array, 0 while shut down |
| off_a | output | 1 | Channel A shutdown flag |
| off_b | output | 1 | Channel B shutdown flag |
| rng_a | output | RANGE_W | Channel A full-scale range index |
| rng_b | output | RANGE_W | Channel B full-scale range index |
| ref_int | output | 1 | 1 = internal reference, 0 = external |

## Verification
Every piece of state is brought out at the ports. A wrong decode or a write to the wrong channel therefore shows on the outputs in the cycle right after the strobe edge, not later in a conversion. A staging register that was corrupted stays hidden from the active path until a transfer, but `hold_*` exposes it at once. The bench compares every output against a behavioural model on every cycle. The code space is walked in a directed pass and then sampled at random, so an undefined code that alters state is caught within one cycle.

// File: rtl/twin_dac_cmdproc.sv
module twin_dac_cmdproc #(
  parameter int DATA_W    = 8,
  parameter int RANGE_W   = 3,
  parameter int RANGE_CNT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [5:0]         cmd_code,
  input  logic [DATA_W-1:0]  cmd_data,
  output logic [DATA_W-1:0]  hold_a,
  output logic [DATA_W-1:0]  hold_b,
  output logic [DATA_W-1:0]  act_a,
  output logic [DATA_W-1:0]  act_b,
  output logic [DATA_W-1:0]  drive_a,
  output logic [DATA_W-1:0]  drive_b,
  output logic               off_a,
  output logic               off_b,
  output logic [RANGE_W-1:0] rng_a,
  output logic [RANGE_W-1:0] rng_b,
  output logic               ref_int
);

  localparam logic [5:0] OP_LDU_AB = 6'b000001;
  localparam logic [5:0] OP_LDU_A  = 6'b000010;
  localparam logic [5:0] OP_LDU_B  = 6'b000011;
  localparam logic [5:0] OP_STG_AB = 6'b000100;
  localparam logic [5:0] OP_STG_A  = 6'b000101;
  localparam logic [5:0] OP_STG_B  = 6'b000110;
  localparam logic [5:0] OP_XF_AB  = 6'b000111;
  localparam logic [5:0] OP_XF_A   = 6'b001001;
  localparam logic [5:0] OP_XF_B   = 6'b001010;
  localparam logic [5:0] OP_REF_IN = 6'b001011;
  localparam logic [5:0] OP_REF_EX = 6'b001100;
  localparam logic [5:0] OP_OFF_AB = 6'b001101;
  localparam logic [5:0] OP_OFF_A  = 6'b001110;
  localparam logic [5:0] OP_OFF_B  = 6'b001111;
  localparam logic [5:0] OP_ON_AB  = 6'b101101;
  localparam logic [5:0] OP_ON_A   = 6'b101110;
  localparam logic [5:0] OP_ON_B   = 6'b101111;
  localparam logic [2:0] RNG_A_HI  = 3'b010;
  localparam logic [2:0] RNG_B_HI  = 3'b110;

  logic go;
  logic rng_ok;
  logic [RANGE_W-1:0] rng_new;

  assign go      = cmd_valid;
  assign rng_ok  = int'(cmd_code[2:0]) < RANGE_CNT;
  assign rng_new = RANGE_W'(cmd_code[2:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_a  <= '0;
      hold_b  <= '0;
      act_a   <= '0;
      act_b   <= '0;
      off_a   <= 1'b0;
      off_b   <= 1'b0;
      rng_a   <= '0;
      rng_b   <= '0;
      ref_int <= 1'b0;
    end else if (go) begin
      case (cmd_code)
        OP_LDU_AB: begin
          hold_a <= cmd_data; hold_b <= cmd_data;
          act_a  <= cmd_data; act_b  <= cmd_data;
        end
        OP_LDU_A:  begin hold_a <= cmd_data; act_a <= cmd_data; end
        OP_LDU_B:  begin hold_b <= cmd_data; act_b <= cmd_data; end
        OP_STG_AB: begin hold_a <= cmd_data; hold_b <= cmd_data; end
        OP_STG_A:  hold_a <= cmd_data;
        OP_STG_B:  hold_b <= cmd_data;
        OP_XF_AB:  begin act_a <= hold_a; act_b <= hold_b; end
        OP_XF_A:   act_a <= hold_a;
        OP_XF_B:   act_b <= hold_b;
        OP_REF_IN: ref_int <= 1'b1;
        OP_REF_EX: ref_int <= 1'b0;
        OP_OFF_AB: begin off_a <= 1'b1; off_b <= 1'b1; end
        OP_OFF_A:  off_a <= 1'b1;
        OP_OFF_B:  off_b <= 1'b1;
        OP_ON_AB:  begin off_a <= 1'b0; off_b <= 1'b0; end
        OP_ON_A:   off_a <= 1'b0;
        OP_ON_B:   off_b <= 1'b0;
        default: begin
          if (cmd_code[5:3] == RNG_A_HI && rng_ok) rng_a <= rng_new;
          if (cmd_code[5:3] == RNG_B_HI && rng_ok) rng_b <= rng_new;
        end
      endcase
    end
  end

  assign drive_a = off_a ? '0 : act_a;
  assign drive_b = off_b ? '0 : act_b;

endmodule

// File: rtl/twin_dac_cmdproc_chk.sv
module twin_dac_cmdproc_chk #(
  parameter int DATA_W    = 8,
  parameter int RANGE_W   = 3,
  parameter int RANGE_CNT = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [5:0]         cmd_code,
  input logic [DATA_W-1:0]  cmd_data,
  input logic [DATA_W-1:0]  hold_a,
  input logic [DATA_W-1:0]  hold_b,
  input logic [DATA_W-1:0]  act_a,
  input logic [DATA_W-1:0]  act_b,
  input logic [DATA_W-1:0]  drive_a,
  input logic [DATA_W-1:0]  drive_b,
  input logic               off_a,
  input logic               off_b,
  input logic [RANGE_W-1:0] rng_a,
  input logic [RANGE_W-1:0] rng_b,
  input logic               ref_int
);

  logic [6*DATA_W+2*RANGE_W+2:0] st;
  assign st = {hold_a, hold_b, act_a, act_b, drive_a, drive_b, off_a, off_b, rng_a, rng_b, ref_int};

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !cmd_valid |=> $stable(st)); // R10
  AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == 6'b000001 |=> act_a == $past(cmd_data) && act_b == $past(cmd_data)); // R2
  AST_STAGE_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == 6'b000100 |=> $stable(act_a) && $stable(act_b)); // R3
  AST_XFER_A: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == 6'b001001 |=> act_a == $past(hold_a) && $stable(act_b)); // R4
  AST_REF_INT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == 6'b001011 |=> ref_int); // R5
  AST_OFF_B_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == 6'b001111 |=> off_b && drive_b == '0 && $stable(act_b)); // R8
  AST_RANGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rng_a) < RANGE_CNT && int'(rng_b) < RANGE_CNT); // R7
  AST_NOOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == 6'b000000 |=> $stable(st)); // R10

endmodule

bind twin_dac_cmdproc twin_dac_cmdproc_chk #(.DATA_W(DATA_W), .RANGE_W(RANGE_W), .RANGE_CNT(RANGE_CNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_data(cmd_data),
  .hold_a(hold_a), .hold_b(hold_b), .act_a(act_a), .act_b(act_b), .drive_a(drive_a), .drive_b(drive_b),
  .off_a(off_a), .off_b(off_b), .rng_a(rng_a), .rng_b(rng_b), .ref_int(ref_int)
);

// File: tb/twin_dac_cmdproc_test.sv
module twin_dac_cmdproc_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [5:0] cmd_code = '0;
  logic [7:0] cmd_data = '0;
  logic [7:0] hold_a, hold_b, act_a, act_b, drive_a, drive_b;
  logic off_a, off_b, ref_int;
  logic [2:0] rng_a, rng_b;

  int checks = 0;
  int fails = 0;
  int m_ha, m_hb, m_aa, m_ab, m_oa, m_ob, m_ra, m_rb, m_ref;

  always #(CLK_P/2) clk = ~clk;

  twin_dac_cmdproc uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_data(cmd_data),
    .hold_a(hold_a), .hold_b(hold_b), .act_a(act_a), .act_b(act_b),
    .drive_a(drive_a), .drive_b(drive_b), .off_a(off_a), .off_b(off_b),
    .rng_a(rng_a), .rng_b(rng_b), .ref_int(ref_int)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "hold_a", int'(hold_a), m_ha);
    chk(tag, "hold_b", int'(hold_b), m_hb);
    chk(tag, "act_a", int'(act_a), m_aa);
    chk(tag, "act_b", int'(act_b), m_ab);
    chk(tag, "drive_a", int'(drive_a), m_oa ? 0 : m_aa);
    chk(tag, "drive_b", int'(drive_b), m_ob ? 0 : m_ab);
    chk(tag, "off_a", int'(off_a), m_oa);
    chk(tag, "off_b", int'(off_b), m_ob);
    chk(tag, "rng_a", int'(rng_a), m_ra);
    chk(tag, "rng_b", int'(rng_b), m_rb);
    chk(tag, "ref_int", int'(ref_int), m_ref);
  endtask

  task automatic model_reset();
    m_ha = 0; m_hb = 0; m_aa = 0; m_ab = 0;
    m_oa = 0; m_ob = 0; m_ra = 0; m_rb = 0; m_ref = 0;
  endtask

  task automatic model_apply(input int v, input int code, input int d);
    int hi, lo;
    if (!v) return;
    hi = code / 8;
    lo = code % 8;
    if (code == 1) begin m_ha = d; m_hb = d; m_aa = d; m_ab = d; end
    else if (code == 2) begin m_ha = d; m_aa = d; end
    else if (code == 3) begin m_hb = d; m_ab = d; end
    else if (code == 4) begin m_ha = d; m_hb = d; end
    else if (code == 5) m_ha = d;
    else if (code == 6) m_hb = d;
    else if (code == 7) begin m_aa = m_ha; m_ab = m_hb; end
    else if (code == 9) m_aa = m_ha;
    else if (code == 10) m_ab = m_hb;
    else if (code == 11) m_ref = 1;
    else if (code == 12) m_ref = 0;
    else if (code == 13) begin m_oa = 1; m_ob = 1; end
    else if (code == 14) m_oa = 1;
    else if (code == 15) m_ob = 1;
    else if (code == 45) begin m_oa = 0; m_ob = 0; end
    else if (code == 46) m_oa = 0;
    else if (code == 47) m_ob = 0;
    else if (hi == 2 && lo < 6) m_ra = lo;
    else if (hi == 6 && lo < 6) m_rb = lo;
  endtask

  // drive on negedge, model updates at the posedge, compare on the following negedge
  task automatic step(input string tag, input int v, input int code, input int d);
    cmd_valid = v[0];
    cmd_code  = code[5:0];
    cmd_data  = d[7:0];
    @(posedge clk);
    model_apply(v, code, d);
    @(negedge clk);
    cmd_valid = 1'b0;
    compare_all(tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    step("R2", 1, 6'b000001, 8'h5A);
    step("R2", 1, 6'b000010, 8'hC3);
    step("R2", 1, 6'b000011, 8'h11);
    step("R3", 1, 6'b000100, 8'h77);
    step("R3", 1, 6'b000101, 8'hE0);
    step("R3", 1, 6'b000110, 8'h0F);
    step("R4", 1, 6'b001001, 8'hFF);
    step("R4", 1, 6'b001010, 8'h00);
    step("R3", 1, 6'b000100, 8'h99);
    step("R4", 1, 6'b000111, 8'h12);
    step("R5", 1, 6'b001011, 8'h00);
    step("R5", 1, 6'b001100, 8'hFF);
    step("R5", 1, 6'b001011, 8'h00);
    step("R6", 1, 6'b001110, 8'h00);
    step("R8", 0, 6'b000000, 8'h00);
    step("R9", 1, 6'b000010, 8'hAB);
    step("R8", 1, 6'b101110, 8'h00);
    step("R6", 1, 6'b001111, 8'h00);
    step("R9", 1, 6'b000110, 8'h3C);
    step("R9", 1, 6'b001010, 8'h00);
    step("R6", 1, 6'b101111, 8'h00);
    step("R6", 1, 6'b001101, 8'h00);
    step("R6", 1, 6'b101101, 8'h00);
    for (int k = 0; k < 8; k++) step("R7", 1, 16 + k, 8'hFF);
    for (int k = 7; k >= 0; k--) step("R7", 1, 48 + k, 8'h00);
    step("R7", 1, 6'b010011, 8'h00);
    step("R7", 1, 6'b010110, 8'h00);
    step("R7", 1, 6'b110111, 8'h00);
    step("R10", 1, 6'b001000, 8'hFF);
    step("R10", 1, 6'b111111, 8'hFF);
    step("R10", 1, 6'b000000, 8'h42);
    step("R10", 0, 6'b000001, 8'h42);
    for (int c = 16; c < 64; c++) step("R10", 1, c, 8'hA5);
    step("R11", 1, 6'b000001, 8'h81);
    step("R11", 0, 6'b000001, 8'h18);

    for (int n = 0; n < 2000; n++)
      step("R10", int'($urandom_range(0, 3) != 0), int'($urandom_range(0, 63)), int'($urandom_range(0, 255)));

    rst_n = 1'b0;
    model_reset();
    @(posedge clk);
    @(negedge clk);
    compare_all("R1");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule